// File: doc/BRIEF.md
# Parallel-Load Shift Register with Inhibit

This block is a parallel-in, serial-out shift register built for a single system clock domain. A word presented on the parallel inputs is captured into the stage chain while the active-low load control is held low. Once load is released, the contents move one stage toward the output end each time the effective shift clock rises, with the serial input filling the first stage. The last stage is presented on the output in true and inverted form.

The external shift clock and inhibit pins are not used as clocks. Both pass through a synchronizer, and the block forms their OR, registers it and detects its rising edge. The two pins are therefore interchangeable: a rise of either one while the other is low produces one shift, and holding either one high freezes the register. Load is level-sensitive and beats any shift that falls in the same cycle. A debug bus exposes every stage so that a reference model can follow the register cycle by cycle.

Top module: `psr_shift_top`

## Requirements
- R1: With `rst_n` low at a rising edge of `clk`, every stage clears to 0 on that edge, so `q_out` reads 0 and `q_out_n` reads 1.
- R2: At every `clk` edge where `load_n` is low, `stage_dbg` takes `par_in` (bit 0 is the first stage, bit WIDTH-1 the last). This holds whatever `shift_clk`, `shift_inh` and `ser_in` are doing, and the register follows a changing `par_in` for as long as `load_n` stays low.
- R3: A rise of `shift_clk` while `shift_inh` is low and `load_n` is high gives exactly one shift. Stage 0 takes `ser_in`, stage i takes stage i-1, and the old last stage is lost.
- R4: A rise of `shift_inh` while `shift_clk` is low gives exactly one shift, the same as in R3.
- R5: While either pin is held high, no shift occurs. A rise of the other pin, the fall of either pin, or both pins returning low all leave the contents unchanged.
- R6: A rising edge of the effective clock that is detected while `load_n` is low is discarded. Once load is released, the contents equal the loaded word and no shift is owed.
- R7: `q_out` always equals the last stage and `q_out_n` is always its complement.
- R8: After a load, successive shifts present the loaded bits from stage WIDTH-2 down to stage 0 on `q_out`, followed by the serial bits in the order they were shifted in.
- R9: A pin rise that is driven just after a `clk` edge changes the outputs at the (SYNC_STAGES+1)-th following `clk` edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_in | input | WIDTH | Parallel data; bit 0 is the first stage |
| ser_in | input | 1 | Serial data that enters stage 0 on a shift |
| load_n | input | 1 | Active-low level-sensitive load |
| shift_clk | input | 1 | Asynchronous shift clock pin |
| shift_inh | input | 1 | Asynchronous inhibit pin, interchangeable with shift_clk |
| q_out | output | 1 | Last stage |
| q_out_n | output | 1 | Complement of the last stage |
| stage_dbg | output | WIDTH | All stage values, for debug |

## Verification
The bench builds the block with WIDTH = 8 and SYNC_STAGES = 2, which puts the shift at the third `clk` edge after a pin rise. That gives a window where the bench can show both "not yet shifted" and "shifted" for R9. With eight stages, a full load-and-drain sequence is short enough to walk every loaded bit out and then follow the serial bits behind it. It also lets a single loaded pattern reveal any stage that is swapped or skipped.

// File: rtl/psr_pkg.sv
// Package: shared types for the parallel-load shift register.
// Assumes: nothing beyond plain SystemVerilog.
package psr_pkg;
    // Stage-chain operation chosen for each clk cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } psr_op_e;

    // Load wins over shift; shift only on a detected edge
    function automatic psr_op_e psr_pick_op(input logic load_n, input logic fire);
        if (!load_n)
            return OP_LOAD;
        else if (fire)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction
endpackage

// File: rtl/psr_sync.sv
// Module: multi-bit, multi-stage flop synchronizer.
// Assumes: each bit is independent (no bus coherency needed); STAGES >= 1.
module psr_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one flop rank of the synchronizer
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pipe[s] <= '0;
                else if (s == 0)
                    pipe[s] <= din;
                else
                    pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/psr_edge_det.sv
// Module: forms the effective shift clock (OR of the two synchronized
// pins) and flags its 0-to-1 transition for one clk cycle.
// Assumes: inputs are already synchronous to clk.
module psr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    input  logic pin_b,
    output logic fire
);
    logic eff;
    logic eff_q;

    assign eff = pin_a | pin_b;

    // Purpose: remember last cycle's effective clock level
    always_ff @(posedge clk) begin
        if (!rst_n)
            eff_q <= 1'b0;
        else
            eff_q <= eff;
    end

    assign fire = eff & ~eff_q;
endmodule

// File: rtl/psr_stage_chain.sv
// Module: WIDTH-stage register chain that holds, loads in parallel, or
// shifts toward the high index with serial data entering stage 0.
// Assumes: op is decided by the caller each cycle; WIDTH >= 2.
module psr_stage_chain
    import psr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  psr_op_e          op,
    input  logic [WIDTH-1:0] par,
    input  logic             ser,
    output logic [WIDTH-1:0] stages
);
    logic [WIDTH-1:0] shifted;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_link
            if (i == 0) begin : g_head
                assign shifted[i] = ser;
            end else begin : g_body
                assign shifted[i] = stages[i-1];
            end
        end
    endgenerate

    // Purpose: update all stages according to the selected operation
    always_ff @(posedge clk) begin
        if (!rst_n)
            stages <= '0;
        else begin
            unique case (op)
                OP_LOAD:  stages <= par;
                OP_SHIFT: stages <= shifted;
                default:  stages <= stages;
            endcase
        end
    end
endmodule

// File: rtl/psr_shift_top.sv
// Module: parallel-load shift register with interchangeable clock and
// inhibit pins sampled in the system clock domain.
// Assumes: shift_clk/shift_inh are asynchronous and slower than clk by
// several cycles per phase; load_n and data inputs are synchronous.
module psr_shift_top
    import psr_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             load_n,
    input  logic             shift_clk,
    input  logic             shift_inh,
    output logic             q_out,
    output logic             q_out_n,
    output logic [WIDTH-1:0] stage_dbg
);
    localparam int NPINS = 2;
    localparam int LAST  = WIDTH - 1;

    logic [NPINS-1:0] pins_raw;
    logic [NPINS-1:0] pins_sync;
    logic             shift_fire;
    psr_op_e          op;
    logic [WIDTH-1:0] stages;

    assign pins_raw = {shift_inh, shift_clk};

    psr_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_sync)
    );

    psr_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_a (pins_sync[0]),
        .pin_b (pins_sync[1]),
        .fire  (shift_fire)
    );

    // Purpose: choose hold/load/shift with load taking priority
    always_comb op = psr_pick_op(load_n, shift_fire);

    psr_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .par    (par_in),
        .ser    (ser_in),
        .stages (stages)
    );

    assign q_out     = stages[LAST];
    assign q_out_n   = ~stages[LAST];
    assign stage_dbg = stages;
endmodule

// File: rtl/psr_shift_checker.sv
// Module: assertion checker bound to psr_shift_top.
// Assumes: stages observed through the debug bus; shift_fire is the
// edge detector's output inside the top.
module psr_shift_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] stages,
    input logic             q,
    input logic             q_n,
    input logic             shift_fire
);
    // R1: reset clears the chain
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (stages == '0));

    // R2: load captures parallel data
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (stages == $past(par_in)));

    // R3: a detected edge with load high moves data one stage
    assert_shift_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && shift_fire) |=>
            (stages[0] == $past(ser_in)) && (stages[WIDTH-1:1] == $past(stages[WIDTH-2:0])));

    // R5: without a detected edge the chain keeps its contents
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !shift_fire) |=> $stable(stages));

    // R3: one edge yields a single-cycle fire pulse
    assert_single_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_fire |=> !shift_fire);

    // R7: outputs track the last stage in both polarities
    assert_out_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q == stages[WIDTH-1]) && (q_n != q));
endmodule

bind psr_shift_top psr_shift_checker #(.WIDTH(WIDTH)) u_psr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .stages     (stage_dbg),
    .q          (q_out),
    .q_n        (q_out_n),
    .shift_fire (shift_fire)
);

// File: tb/test_psr_shift_top.sv
module test_psr_shift_top;
    localparam int W  = 8;
    localparam int SS = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] par_in;
    logic         ser_in;
    logic         load_n;
    logic         shift_clk;
    logic         shift_inh;
    logic         q_out;
    logic         q_out_n;
    logic [W-1:0] stage_dbg;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [W-1:0] model;

    always #2 clk = ~clk;

    psr_shift_top #(.WIDTH(W), .SYNC_STAGES(SS)) i_psr_shift_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_in    (par_in),
        .ser_in    (ser_in),
        .load_n    (load_n),
        .shift_clk (shift_clk),
        .shift_inh (shift_inh),
        .q_out     (q_out),
        .q_out_n   (q_out_n),
        .stage_dbg (stage_dbg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check(stage_dbg == model, tag, stage_dbg, model);
        check((q_out == model[W-1]) && (q_out_n == ~model[W-1]), {tag, " R7 out"},
              {6'd0, q_out, q_out_n}, {6'd0, model[W-1], ~model[W-1]});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; load_n = 1'b1; shift_clk = 1'b0; shift_inh = 1'b0;
        ser_in = 1'b0; par_in = '0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        model = '0;
    endtask

    task automatic load_word(input logic [W-1:0] v);
        load_n = 1'b0; par_in = v;
        tick(1);
        load_n = 1'b1;
        tick(1);
        model = v;
    endtask

    // One rise and fall of a pin; checks R9 latency and R3/R4 result
    task automatic pulse(input bit use_inh, input logic s, input string tag);
        ser_in = s;
        if (use_inh) shift_inh = 1'b1; else shift_clk = 1'b1;
        tick(SS);
        check_state({tag, " R9 not yet"});
        tick(1);
        model = {model[W-2:0], s};
        check_state(tag);
        if (use_inh) shift_inh = 1'b0; else shift_clk = 1'b0;
        tick(SS + 2);
        check_state({tag, " R5 fall no shift"});
    endtask

    task automatic t_reset();
        model = '0;
        check_state("R1 reset");
        load_word(8'hA5);
        rst_n = 1'b0; tick(1); rst_n = 1'b1; tick(1);
        model = '0;
        check_state("R1 reset after load");
    endtask

    task automatic t_load();
        load_n = 1'b0; par_in = 8'h3C; ser_in = 1'b1;
        tick(1);
        model = 8'h3C;
        check_state("R2 load");
        shift_clk = 1'b1; tick(2); shift_clk = 1'b0; shift_inh = 1'b1; tick(2);
        par_in = 8'hC3; tick(1);
        model = 8'hC3;
        check_state("R2 follow while low");
        shift_inh = 1'b0; tick(SS + 2);
        load_n = 1'b1; tick(SS + 2);
        check_state("R2 pins ignored");
    endtask

    task automatic t_shift_clk();
        load_word(8'h96);
        pulse(1'b0, 1'b1, "R3 clk shift 1");
        pulse(1'b0, 1'b0, "R3 clk shift 0");
    endtask

    task automatic t_shift_inh();
        load_word(8'h5A);
        pulse(1'b1, 1'b1, "R4 inh shift 1");
        pulse(1'b1, 1'b0, "R4 inh shift 0");
    endtask

    task automatic t_hold();
        load_word(8'h81);
        shift_clk = 1'b1; ser_in = 1'b1; tick(SS + 2);
        model = {model[W-2:0], 1'b1};
        check_state("R5 first rise shifts");
        shift_inh = 1'b1; tick(SS + 3);
        check_state("R5 inh rise while clk high");
        shift_clk = 1'b0; tick(SS + 3);
        check_state("R5 clk fall while inh high");
        shift_clk = 1'b1; tick(SS + 3);
        check_state("R5 clk rise while inh high");
        shift_clk = 1'b0; shift_inh = 1'b0; tick(SS + 3);
        check_state("R5 both low");
    endtask

    task automatic t_priority();
        load_n = 1'b0; par_in = 8'h6E; ser_in = 1'b1;
        shift_clk = 1'b1;
        tick(SS + 3);
        load_n = 1'b1;
        tick(SS + 3);
        model = 8'h6E;
        check_state("R6 edge during load dropped");
        shift_clk = 1'b0; tick(SS + 2);
        check_state("R6 no owed shift");
    endtask

    task automatic t_sequence();
        logic [W-1:0] word;
        logic [3:0]   sbits;
        word  = 8'b1011_0010;
        sbits = 4'b0110;
        load_word(word);
        check(q_out == word[W-1], "R8 first out", {7'd0, q_out}, {7'd0, word[W-1]});
        for (int k = 1; k < W + 4; k++) begin
            logic s;
            logic e;
            s = sbits[(k - 1) % 4];
            ser_in = s;
            shift_clk = 1'b1; tick(SS + 1);
            shift_clk = 1'b0; tick(SS + 1);
            model = {model[W-2:0], s};
            e = (k < W) ? word[W-1-k] : sbits[k - W];
            check(q_out == e, "R8 drain order", {7'd0, q_out}, {7'd0, e});
        end
        check_state("R8 final");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_load();
        t_shift_clk();
        t_shift_inh();
        t_hold();
        t_priority();
        t_sequence();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule